// File: doc/BRIEF.md
# Host Task Handshake Controller

This block is the host-side front end of a modem datapath. A microcontroller reaches it through one byte-wide register port. The port has four registers: a command register, a data window into a small block buffer, a mode register and a status register. Writing a command byte starts a task. The task's code is held in the low three bits of the byte, and bit 6 of the same byte can request a restart of receive level acquisition.

A buffer-free flag hands the block buffer back and forth between the host and the datapath. In transmit mode the host fills the buffer and then writes a task. The block then streams the bytes out to the interleave stage on a valid/ready port. Once the last byte has left, the buffer is free again, so the host can prepare the next block while the previous one is still draining downstream. In receive mode the host writes a task first. The block collects the required number of decoded bytes from a valid/ready input, and then hands the buffer back. A separate task copies the first buffer bytes into a frame-sync comparison pattern.

Back-pressure rules: on the output, a byte moves only on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold steady. On the input, a byte is taken only on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is high only while a receive task still needs bytes. Neither stream has any buffering beyond the block buffer.

Top module: `hth_ctrl`

## Requirements
- R1: The register select `host_sel` picks 0=command, 1=data, 2=mode, 3=status. In a command byte, bits 2..0 are the task code: 0 is NULL and has no effect on any task state, 7 is RESET, 1..5 are transfer tasks of that many bytes, and 6 is the sync-load task. Bit 6 is acquisition restart, bits 5..3 are reserved, and bit 7 is ignored.
- R2: After reset, status reads 0x01 (bit 0 buffer-free=1, bit 1 irq=0, bit 2 error=0), mode reads 0 and no stream is active. An accepted task (codes 1..6 with buffer-free=1) clears buffer-free at the next clock edge.
- R3: In transmit mode (mode bit 0 = 1), `tx_valid` rises the cycle after a transfer task is accepted. It presents buffer bytes 0..N-1 in order, advances only on a handshake, and holds `tx_data` while stalled.
- R4: The clock edge of the final transmit handshake sets buffer-free and the irq status bit.
- R5: In receive mode (mode bit 0 = 0), `rx_ready` is high from the cycle after a transfer task is accepted until N bytes have been taken. Byte i is stored at buffer position i. Completion then sets buffer-free and irq, and host data reads return byte 0 first.
- R6: `irq_n` is low exactly while the irq status bit is 1 and the interrupt-enable bit (mode bit 1) is 1.
- R7: A status read clears the irq status bit at the next edge.
- R8: Every command write with bit 6 = 1 and reserved bits 0 gives a one-cycle `acq_restart` pulse on the following cycle, whatever the buffer-free state. A write with bit 6 = 0 gives no pulse.
- R9: A command byte with any of bits 5..3 set is ignored entirely (no task, no pulse) and sets the error bit.
- R10: While buffer-free is 0, task codes 1..6, data writes, data reads and mode writes are ignored, and each sets the error bit.
- R11: The RESET code is accepted at any time. It abandons the running task, drops `tx_valid` and `rx_ready`, and leaves status at 0x01 with both host buffer pointers at 0.
- R12: The sync-load task copies buffer bytes 0..SYNC_BYTES-1 into `sync_pat`, with byte 0 in the low bits. The bytes must already be in the buffer when the task is written. Completion then sets buffer-free and irq.
- R13: Host data writes fill buffer positions from 0 upward. Both host pointers return to 0 when a task is accepted, so each block starts at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects on data and status) |
| host_sel | input | 2 | Register select |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected register |
| irq_n | output | 1 | Active-low interrupt |
| acq_restart | output | 1 | One-cycle level-acquisition restart pulse |
| sync_pat | output | 8*SYNC_BYTES | Frame-sync comparison pattern |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Interleave stage can accept a byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Decoded receive byte valid |
| rx_ready | output | 1 | Block can accept a receive byte |
| rx_data | input | 8 | Decoded receive byte |

## Verification
The bench stalls the transmit stream while a task is busy and then tries data writes, second tasks and mode writes. A design that let any of these through would send an extra byte, switch mode mid-block, or fail to raise the error bit. Other checks cover a reserved-bit command, which a sloppy decoder would either run or turn into an acquisition pulse. A RESET in the middle of a stalled transfer must drop `tx_valid` at once, and a design that only waited for idle would keep streaming. Further checks cover back-to-back blocks, where a pointer left unreset would send stale bytes; receive with random gaps, where a wrong index would reorder the block; and interrupt masking, where `irq_n` would fall with interrupts disabled.

// File: rtl/hth_pkg.sv
package hth_pkg;
  localparam logic [2:0] TASK_NULL  = 3'd0;
  localparam logic [2:0] TASK_SYNC  = 3'd6;
  localparam logic [2:0] TASK_RESET = 3'd7;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2,
    ST_SYNC = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [2:0] code;
    logic       acq;
    logic       rsv_bad;
    logic       is_null;
    logic       is_reset;
    logic       is_sync;
  } cmd_info_t;
endpackage

// File: rtl/hth_cmd_dec.sv
module hth_cmd_dec
  import hth_pkg::*;
(
  input  logic [6:0] cmd_byte,
  output cmd_info_t  info
);
  always_comb begin
    info.code     = cmd_byte[2:0];
    info.acq      = cmd_byte[6];
    info.rsv_bad  = |cmd_byte[5:3];
    info.is_null  = (cmd_byte[2:0] == TASK_NULL);
    info.is_reset = (cmd_byte[2:0] == TASK_RESET);
    info.is_sync  = (cmd_byte[2:0] == TASK_SYNC);
  end
endmodule

// File: rtl/hth_buf.sv
module hth_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (we && (waddr == AW'(i)))
        mem[i] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/hth_seq.sv
module hth_seq
  import hth_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int SYNC_BYTES = 2,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  cmd_info_t     info,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic          mode_wr,
  input  logic [1:0]    mode_wdata,
  input  logic          stat_rd,
  input  logic          tx_ready,
  input  logic          rx_valid,
  output logic          tx_valid,
  output logic          rx_ready,
  output logic [AW-1:0] xfer_idx,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          host_we,
  output logic          rx_we,
  output logic          sync_shift,
  output logic          bfree,
  output logic          irq,
  output logic          err,
  output logic          tx_mode,
  output logic          irq_en,
  output logic          acq_restart
);
  seq_state_t    st;
  logic [AW-1:0] cnt;
  logic [AW-1:0] len;
  logic          task_req, start_ok, reset_cmd, last, step;

  assign reset_cmd  = cmd_wr && !info.rsv_bad && info.is_reset;
  assign task_req   = cmd_wr && !info.rsv_bad && !info.is_null && !info.is_reset;
  assign start_ok   = task_req && bfree;
  assign last       = (cnt == len - 1'b1);
  assign tx_valid   = (st == ST_TX);
  assign rx_ready   = (st == ST_RX);
  assign sync_shift = (st == ST_SYNC);
  assign rx_we      = rx_ready && rx_valid;
  assign host_we    = data_wr && bfree;
  assign xfer_idx   = cnt;

  always_comb begin
    unique case (st)
      ST_TX:   step = tx_ready;
      ST_RX:   step = rx_valid;
      ST_SYNC: step = 1'b1;
      default: step = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      len         <= '0;
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      bfree       <= 1'b1;
      irq         <= 1'b0;
      err         <= 1'b0;
      tx_mode     <= 1'b0;
      irq_en      <= 1'b0;
      acq_restart <= 1'b0;
    end else begin
      acq_restart <= cmd_wr && !info.rsv_bad && info.acq;
      if (stat_rd) irq <= 1'b0;
      if (data_wr) begin
        if (bfree) wr_ptr <= wr_ptr + 1'b1;
        else       err    <= 1'b1;
      end
      if (data_rd) begin
        if (bfree) rd_ptr <= rd_ptr + 1'b1;
        else       err    <= 1'b1;
      end
      if (mode_wr) begin
        if (bfree) begin
          tx_mode <= mode_wdata[0];
          irq_en  <= mode_wdata[1];
        end else begin
          err <= 1'b1;
        end
      end
      if (cmd_wr && info.rsv_bad) err <= 1'b1;
      if (task_req && !bfree)     err <= 1'b1;
      if (start_ok) begin
        bfree  <= 1'b0;
        cnt    <= '0;
        wr_ptr <= '0;
        rd_ptr <= '0;
        if (info.is_sync) begin
          st  <= ST_SYNC;
          len <= AW'(SYNC_BYTES);
        end else begin
          st  <= tx_mode ? ST_TX : ST_RX;
          len <= AW'(info.code);
        end
      end
      if (step) begin
        if (last) begin
          st    <= ST_IDLE;
          cnt   <= '0;
          bfree <= 1'b1;
          irq   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (reset_cmd) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        wr_ptr <= '0;
        rd_ptr <= '0;
        bfree  <= 1'b1;
        irq    <= 1'b0;
        err    <= 1'b0;
      end
    end
  end

  // R2
  start_clears_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !bfree);

  // R3
  tx_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !reset_cmd) |=> (tx_valid && $stable(cnt)));

  // R4
  tx_done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && last && !reset_cmd) |=> (bfree && irq));

  // R8
  acq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_restart |-> $past(cmd_wr && info.acq));

  // R10
  busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !bfree) |=> err);

  // R11
  reset_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (bfree && !irq && !tx_valid && !rx_ready));
endmodule

// File: rtl/hth_ctrl.sv
module hth_ctrl
  import hth_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int SYNC_BYTES = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int SP_W      = 8 * SYNC_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [1:0]      host_sel,
  input  logic [7:0]      host_wdata,
  output logic [7:0]      host_rdata,
  output logic            irq_n,
  output logic            acq_restart,
  output logic [SP_W-1:0] sync_pat,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [7:0]      tx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [7:0]      rx_data
);
  cmd_info_t     info;
  logic          cmd_wr, data_wr, data_rd, mode_wr, stat_rd;
  logic [AW-1:0] xfer_idx, wr_ptr, rd_ptr, buf_waddr;
  logic          host_we, rx_we, sync_shift, buf_we;
  logic          bfree, irq, err, tx_mode, irq_en;
  logic [7:0]    buf_wdata, host_byte, xfer_byte;

  assign cmd_wr  = host_wr && (host_sel == SEL_CMD);
  assign data_wr = host_wr && (host_sel == SEL_DATA);
  assign mode_wr = host_wr && (host_sel == SEL_MODE);
  assign data_rd = host_rd && (host_sel == SEL_DATA);
  assign stat_rd = host_rd && (host_sel == SEL_STAT);

  hth_cmd_dec u_dec (
    .cmd_byte (host_wdata[6:0]),
    .info     (info)
  );

  hth_seq #(.DEPTH(DEPTH), .SYNC_BYTES(SYNC_BYTES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .info        (info),
    .data_wr     (data_wr),
    .data_rd     (data_rd),
    .mode_wr     (mode_wr),
    .mode_wdata  (host_wdata[1:0]),
    .stat_rd     (stat_rd),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .tx_valid    (tx_valid),
    .rx_ready    (rx_ready),
    .xfer_idx    (xfer_idx),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .host_we     (host_we),
    .rx_we       (rx_we),
    .sync_shift  (sync_shift),
    .bfree       (bfree),
    .irq         (irq),
    .err         (err),
    .tx_mode     (tx_mode),
    .irq_en      (irq_en),
    .acq_restart (acq_restart)
  );

  assign buf_we    = host_we || rx_we;
  assign buf_waddr = rx_we ? xfer_idx : wr_ptr;
  assign buf_wdata = rx_we ? rx_data : host_wdata;

  hth_buf #(.DEPTH(DEPTH), .W(8)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .raddr_a (rd_ptr),
    .rdata_a (host_byte),
    .raddr_b (xfer_idx),
    .rdata_b (xfer_byte)
  );

  assign tx_data = xfer_byte;

  if (SYNC_BYTES > 1) begin : g_sync_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sync_pat <= '0;
      else if (sync_shift) sync_pat <= {xfer_byte, sync_pat[SP_W-1:8]};
    end
  end else begin : g_sync_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sync_pat <= '0;
      else if (sync_shift) sync_pat <= xfer_byte;
    end
  end

  always_comb begin
    unique case (host_sel)
      SEL_DATA: host_rdata = host_byte;
      SEL_MODE: host_rdata = {6'b0, irq_en, tx_mode};
      SEL_STAT: host_rdata = {5'b0, err, irq, bfree};
      default:  host_rdata = 8'h00;
    endcase
  end

  assign irq_n = ~(irq & irq_en);
endmodule

// File: tb/hth_ctrl_bench.sv
module hth_ctrl_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        irq_n, acq_restart, tx_valid, rx_ready;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  tx_data, rx_data;
  logic [15:0] sync_pat;

  hth_ctrl u_hth_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_n(irq_n), .acq_restart(acq_restart), .sync_pat(sync_pat),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit stall = 1'b0;
  bit done = 1'b0;
  logic [7:0] txcap[$];
  logic [7:0] rxq[$];

  // behavioural reference model
  logic [7:0]  mbuf [DEPTH];
  int          m_wp, m_rp, m_st, m_cnt, m_len;
  bit          m_bfree, m_irq, m_err, m_txm, m_ien, m_acq;
  logic [15:0] m_sync;
  bit          cw, dw, mw, dr, sr, rsv, bf0, adv;
  int          code, st0, cnt0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  assign rx_data = (rxq.size() > 0) ? rxq[0] : 8'h00;

  always @(negedge clk) begin
    tx_ready <= stall ? 1'b0 : ($urandom_range(3) != 0);
    rx_valid <= (rxq.size() > 0) && ($urandom_range(2) != 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mbuf[i]) mbuf[i] = 8'h00;
      m_wp = 0; m_rp = 0; m_st = 0; m_cnt = 0; m_len = 0;
      m_bfree = 1; m_irq = 0; m_err = 0; m_txm = 0; m_ien = 0; m_acq = 0;
      m_sync = 16'h0;
    end else begin
      if (tx_valid && tx_ready) txcap.push_back(tx_data);
      cw = host_wr && host_sel == 2'd0;
      dw = host_wr && host_sel == 2'd1;
      mw = host_wr && host_sel == 2'd2;
      dr = host_rd && host_sel == 2'd1;
      sr = host_rd && host_sel == 2'd3;
      rsv = host_wdata[5:3] != 3'b000;
      code = int'(host_wdata[2:0]);
      bf0 = m_bfree; st0 = m_st; cnt0 = m_cnt;
      m_acq = cw && !rsv && host_wdata[6];
      if (sr) m_irq = 0;
      if (dw) begin
        if (bf0) begin mbuf[m_wp] = host_wdata; m_wp = (m_wp + 1) % DEPTH; end
        else m_err = 1;
      end
      if (dr) begin
        if (bf0) m_rp = (m_rp + 1) % DEPTH; else m_err = 1;
      end
      if (mw) begin
        if (bf0) begin m_txm = host_wdata[0]; m_ien = host_wdata[1]; end
        else m_err = 1;
      end
      adv = 0;
      if (st0 == 1 && tx_ready) adv = 1;
      if (st0 == 2 && rx_valid) begin
        adv = 1; mbuf[cnt0] = rx_data;
        void'(rxq.pop_front());
      end
      if (st0 == 3) begin adv = 1; m_sync = {mbuf[cnt0], m_sync[15:8]}; end
      if (adv) begin
        if (cnt0 == m_len - 1) begin m_st = 0; m_cnt = 0; m_bfree = 1; m_irq = 1; end
        else m_cnt = cnt0 + 1;
      end
      if (cw) begin
        if (rsv) m_err = 1;
        else if (code == 7) begin
          m_st = 0; m_cnt = 0; m_wp = 0; m_rp = 0; m_bfree = 1; m_irq = 0; m_err = 0;
        end else if (code != 0) begin
          if (bf0) begin
            m_bfree = 0; m_cnt = 0; m_wp = 0; m_rp = 0;
            m_len = (code == 6) ? 2 : code;
            m_st = (code == 6) ? 3 : (m_txm ? 1 : 2);
          end else m_err = 1;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(tx_valid == (m_st == 1), "R3", "tx_valid", tx_valid, m_st == 1);
      if (m_st == 1) chk(tx_data == mbuf[m_cnt], "R3", "tx_data", tx_data, mbuf[m_cnt]);
      chk(rx_ready == (m_st == 2), "R5", "rx_ready", rx_ready, m_st == 2);
      chk(irq_n == !(m_irq && m_ien), "R6", "irq_n", irq_n, !(m_irq && m_ien));
      chk(acq_restart == m_acq, "R8", "acq_restart", acq_restart, m_acq);
      chk(sync_pat == m_sync, "R12", "sync_pat", sync_pat, m_sync);
      case (host_sel)
        2'd1: chk(host_rdata == mbuf[m_rp], "R13", "data rd", host_rdata, mbuf[m_rp]);
        2'd2: chk(host_rdata == {6'b0, m_ien, m_txm}, "R1", "mode rd", host_rdata, {m_ien, m_txm});
        2'd3: chk(host_rdata == {5'b0, m_err, m_irq, m_bfree}, "R2", "status rd",
                  host_rdata, {m_err, m_irq, m_bfree});
        default: chk(host_rdata == 8'h00, "R1", "cmd rd", host_rdata, 0);
      endcase
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); host_sel = s; host_rd = 1'b1; #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wait_free();
    for (int n = 0; n < 5000 && !m_bfree; n++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd3, v); chk(v == 8'h01, "R2", "status after reset", v, 8'h01);
    chk(irq_n == 1'b1, "R6", "irq_n after reset", irq_n, 1);

    // transmit block, bytes in order, acquisition pulse
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33);
    txcap.delete();
    wr(2'd0, 8'h43);
    chk(acq_restart == 1'b1, "R8", "acq pulse", acq_restart, 1);
    wait_free();
    chk(txcap.size() == 3, "R3", "tx count", txcap.size(), 3);
    for (int i = 0; i < 3 && i < txcap.size(); i++)
      chk(txcap[i] == 8'(8'h11 * (i + 1)), "R3", "tx order", txcap[i], 8'h11 * (i + 1));
    chk(irq_n == 1'b0, "R6", "irq_n low", irq_n, 0);
    rd(2'd3, v); chk(v == 8'h03, "R4", "status after tx", v, 8'h03);
    chk(irq_n == 1'b1, "R7", "irq cleared by status read", irq_n, 1);

    // busy accesses are ignored
    stall = 1'b1; repeat (2) @(negedge clk);
    wr(2'd1, 8'hAA); wr(2'd1, 8'hBB);
    txcap.delete();
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h99); wr(2'd0, 8'h01); wr(2'd2, 8'h00);
    rd(2'd3, v); chk(v == 8'h04, "R10", "status while busy", v, 8'h04);
    chk(tx_valid && tx_data == 8'hAA, "R3", "stalled byte held", tx_data, 8'hAA);
    stall = 1'b0;
    wait_free();
    chk(txcap.size() == 2 && txcap[0] == 8'hAA && txcap[txcap.size()-1] == 8'hBB,
        "R10", "busy write ignored", txcap.size(), 2);
    rd(2'd2, v); chk(v == 8'h03, "R10", "mode unchanged", v, 8'h03);
    wr(2'd0, 8'h07);
    rd(2'd3, v); chk(v == 8'h01, "R11", "status after reset code", v, 8'h01);

    // reserved bits
    wr(2'd0, 8'h4A);
    chk(acq_restart == 1'b0, "R9", "no pulse on reserved", acq_restart, 0);
    rd(2'd3, v); chk(v == 8'h05, "R9", "reserved sets error", v, 8'h05);
    wr(2'd0, 8'h07);

    // reset in the middle of a stalled transfer
    stall = 1'b1; repeat (2) @(negedge clk);
    wr(2'd1, 8'h5A); wr(2'd0, 8'h01);
    chk(tx_valid == 1'b1, "R3", "tx_valid after task", tx_valid, 1);
    wr(2'd0, 8'h07);
    chk(tx_valid == 1'b0, "R11", "tx dropped by reset code", tx_valid, 0);
    stall = 1'b0;

    // NULL with and without acquisition
    wr(2'd0, 8'h40);
    chk(acq_restart == 1'b1, "R8", "NULL acq pulse", acq_restart, 1);
    rd(2'd3, v); chk(v == 8'h01, "R1", "NULL starts nothing", v, 8'h01);
    wr(2'd0, 8'h00);
    chk(acq_restart == 1'b0, "R8", "no pulse bit6 clear", acq_restart, 0);

    // receive block with gaps
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h04);
    for (int i = 0; i < 4; i++) rxq.push_back(8'(8'h50 + i));
    wait_free();
    chk(irq_n == 1'b0, "R5", "rx completion irq", irq_n, 0);
    for (int i = 0; i < 4; i++) begin
      rd(2'd1, v); chk(v == 8'(8'h50 + i), "R5", "rx byte order", v, 8'h50 + i);
    end
    rd(2'd3, v);

    // sync-pattern load
    wr(2'd1, 8'hA1); wr(2'd1, 8'hB2);
    wr(2'd0, 8'h06);
    wait_free();
    chk(sync_pat == 16'hB2A1, "R12", "sync pattern", sync_pat, 16'hB2A1);
    rd(2'd3, v); chk(v == 8'h03, "R12", "sync completion status", v, 8'h03);

    // pointers restart per block, irq masked
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
    txcap.delete();
    wr(2'd0, 8'h01);
    wait_free();
    chk(txcap.size() == 1 && txcap[0] == 8'h01, "R13", "byte 0 first", txcap[0], 8'h01);
    chk(irq_n == 1'b1, "R6", "irq masked", irq_n, 1);
    wr(2'd1, 8'h0C); wr(2'd0, 8'h01);
    wait_free();
    chk(txcap.size() == 2 && txcap[txcap.size()-1] == 8'h0C, "R13", "pointer reset",
        txcap[txcap.size()-1], 8'h0C);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule